// File: doc/BRIEF.md
# Inline ECC Access Sequencer

This block protects a data memory with single-error-correct, double-error-detect check codes on a memory port that is exactly one data word wide. Because there are no spare lanes for check bits, the codes are kept inside the same RAM, in a reserved region that starts at a fixed base address. The block translates every host access into a pair of memory commands. A write becomes a data write followed by a write of the matching check word. A read becomes a data read followed by a read of the check word. The read result is then decoded, corrected if one bit is wrong, and returned with status flags.

On the host side there is a valid/ready request channel and a valid/ready response channel. Only reads produce a response. On the memory side the block drives a single-port synchronous RAM with a one-cycle read latency. Only one host request is in flight at a time. The request channel stays closed until the current command pair, and any read response, has completed.

Top module: `inline_ecc_sequencer`

## Requirements
- R1: After reset, `req_ready` is 1 and both `rsp_valid` and `mem_en` are 0.
- R2: In the cycle after a write request is accepted, the block issues a memory write (`mem_en`=1, `mem_we`=1) to the host address, zero-extended, carrying the host write data unchanged.
- R3: In the cycle after the data write, the block issues a memory write to `ECC_BASE` plus the host address. Bits [6:0] of that word hold the check code and all upper bits are 0. The code places data bits, in ascending order, at the codeword positions 1..38 that are not powers of two. Check bit k (k=0..5) is the XOR of every position whose index has bit k set. Check bit 6 is the XOR of all 32 data bits and check bits 0..5.
- R4: In the cycle after a read request is accepted, the block issues a memory read (`mem_en`=1, `mem_we`=0) of the host address. In the next cycle it issues a read of `ECC_BASE` plus the host address.
- R5: `rsp_valid` rises three cycles after the data read command. With no error, the response returns the stored data and both flags are 0.
- R6: If exactly one data bit of the stored word is flipped, the response returns the original data with `rsp_corrected`=1 and `rsp_uncorrectable`=0.
- R7: If exactly one of the seven stored check bits is flipped, including bit 6, the response returns the unmodified data with `rsp_corrected`=1 and `rsp_uncorrectable`=0.
- R8: If two bits of the stored data/check pair are flipped, whether two data bits or one data bit and one of check bits 0..5, the response has `rsp_uncorrectable`=1 and `rsp_corrected`=0.
- R9: `req_ready` is 0 from the cycle after a request is accepted until the sequence ends. A pending response holds its valid and data stable until `rsp_ready` is 1.
- R10: No memory command is issued while the block is idle, while it waits for the check word, or while it holds a response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | HADDR_W | Host word address |
| req_wdata | input | DATA_W | Host write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Host takes the response |
| rsp_rdata | output | DATA_W | Corrected read data |
| rsp_corrected | output | 1 | A single-bit error was repaired |
| rsp_uncorrectable | output | 1 | A multi-bit error was detected |
| mem_en | output | 1 | Memory command strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | MADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, one cycle after a read |

## Verification
The bench corrupts stored words between a write and its read-back. It flips the lowest and highest data bits, where an off-by-one in the position mapping would repair the wrong bit or none at all. It flips the overall parity bit alone, which a decoder that only looks at the syndrome would miss or report as uncorrectable. It also mixes a data-bit flip with a check-bit flip; a decoder that treated any nonzero syndrome as correctable would return silently wrong data in that case. Cycle-exact checks on the command pair catch a check word written to the data address or issued in the wrong order. Holding the response for an extra cycle exposes a response that drops before it is taken.

// File: rtl/iecc_pkg.sv
package iecc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WDAT,
    ST_WECC,
    ST_RDAT,
    ST_RECC,
    ST_RWAIT,
    ST_RESP
  } seq_state_e;

  // smallest Hamming check-bit count p with 2^p >= dw + p + 1
  function automatic int par_bits(int dw);
    int p;
    p = 1;
    while ((1 << p) < dw + p + 1) p++;
    return p;
  endfunction

endpackage

// File: rtl/iecc_encoder.sv
module iecc_encoder #(
  parameter int DATA_W = 32,
  parameter int PAR_W  = 6
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [PAR_W:0]    code_o
);
  localparam int CW = DATA_W + PAR_W;

  logic [PAR_W-1:0] par;
  int               di;

  always_comb begin
    par = '0;
    di  = 0;
    for (int j = 1; j <= CW; j++) begin
      if ((j & (j - 1)) != 0) begin
        for (int k = 0; k < PAR_W; k++) begin
          if (((j >> k) & 1) == 1) par[k] = par[k] ^ data_i[di];
        end
        di = di + 1;
      end
    end
    code_o = {(^data_i) ^ (^par), par};
  end

endmodule

// File: rtl/iecc_decoder.sv
module iecc_decoder #(
  parameter int DATA_W = 32,
  parameter int PAR_W  = 6
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [PAR_W:0]    code_i,
  output logic [DATA_W-1:0] data_o,
  output logic              corrected_o,
  output logic              uncorr_o
);
  localparam int CW = DATA_W + PAR_W;

  logic [PAR_W:0]    recomp;
  logic [PAR_W-1:0]  syn;
  logic              odd;
  logic              syn_pow2;
  logic              hit;
  logic [DATA_W-1:0] flip;
  int                di;

  iecc_encoder #(.DATA_W(DATA_W), .PAR_W(PAR_W)) enc_i (
    .data_i (data_i),
    .code_o (recomp)
  );

  assign syn      = recomp[PAR_W-1:0] ^ code_i[PAR_W-1:0];
  // parity of the whole stored codeword, derived from the recomputed code
  assign odd      = recomp[PAR_W] ^ code_i[PAR_W] ^ (^syn);
  assign syn_pow2 = (syn != '0) && ((syn & (syn - 1'b1)) == '0);

  always_comb begin
    flip = '0;
    hit  = 1'b0;
    di   = 0;
    for (int j = 1; j <= CW; j++) begin
      if ((j & (j - 1)) != 0) begin
        if (j == int'(syn)) begin
          flip[di] = 1'b1;
          hit      = 1'b1;
        end
        di = di + 1;
      end
    end
  end

  always_comb begin
    uncorr_o    = (!odd && (syn != '0)) ||
                  (odd && (syn != '0) && !syn_pow2 && !hit);
    corrected_o = odd && !uncorr_o;
    data_o      = corrected_o ? (data_i ^ flip) : data_i;
  end

endmodule

// File: rtl/iecc_seq.sv
module iecc_seq
  import iecc_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int HADDR_W  = 4,
  parameter int MADDR_W  = 5,
  parameter int ECC_BASE = 16,
  parameter int PAR_W    = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [HADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               req_ready,
  input  logic               rsp_ready,
  output logic               rsp_valid,
  output logic               mem_en,
  output logic               mem_we,
  output logic [MADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata,
  input  logic [PAR_W:0]     enc_code,
  output logic [DATA_W-1:0]  wdata_q,
  output logic [DATA_W-1:0]  rd_data_q,
  output logic [PAR_W:0]     rd_code_q
);
  localparam int                 PAD_W    = DATA_W - PAR_W - 1;
  localparam logic [MADDR_W-1:0] BASE_M   = MADDR_W'(ECC_BASE);

  seq_state_e         st_q, st_d;
  logic [HADDR_W-1:0] addr_q;
  logic               accept;
  logic               cap_data;
  logic               cap_code;
  logic [MADDR_W-1:0] data_addr;

  assign accept   = req_valid && req_ready;
  assign cap_data = (st_q == ST_RECC);
  assign cap_code = (st_q == ST_RWAIT);

  // next state
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (req_valid) st_d = req_write ? ST_WDAT : ST_RDAT;
      ST_WDAT:  st_d = ST_WECC;
      ST_WECC:  st_d = ST_IDLE;
      ST_RDAT:  st_d = ST_RECC;
      ST_RECC:  st_d = ST_RWAIT;
      ST_RWAIT: st_d = ST_RESP;
      ST_RESP:  if (rsp_ready) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rd_data_q <= '0;
    else if (cap_data) rd_data_q <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rd_code_q <= '0;
    else if (cap_code) rd_code_q <= mem_rdata[PAR_W:0];
  end

  // outputs
  assign data_addr = MADDR_W'(addr_q);

  always_comb begin
    req_ready = (st_q == ST_IDLE);
    rsp_valid = (st_q == ST_RESP);
    mem_en    = (st_q == ST_WDAT) || (st_q == ST_WECC) ||
                (st_q == ST_RDAT) || (st_q == ST_RECC);
    mem_we    = (st_q == ST_WDAT) || (st_q == ST_WECC);
    mem_addr  = ((st_q == ST_WECC) || (st_q == ST_RECC)) ?
                (data_addr + BASE_M) : data_addr;
    mem_wdata = (st_q == ST_WECC) ? {{PAD_W{1'b0}}, enc_code} : wdata_q;
  end

  // R3
  // wr_pair_chk: data write is followed by a check write at base offset
  wr_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WDAT) |=> (mem_en && mem_we && (mem_addr == $past(mem_addr) + BASE_M)));

  // R4
  // rd_pair_chk: data read is followed by a check read at base offset
  rd_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we && (st_q == ST_RDAT)) |=>
      (mem_en && !mem_we && (mem_addr == $past(mem_addr) + BASE_M)));

  // R9
  // busy_chk: an accepted request closes the request channel
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  // R10
  // quiet_resp_chk: no memory traffic while a response is pending
  quiet_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !mem_en);

endmodule

// File: rtl/inline_ecc_sequencer.sv
module inline_ecc_sequencer #(
  parameter int DATA_W   = 32,
  parameter int HADDR_W  = 4,
  parameter int MADDR_W  = HADDR_W + 1,
  parameter int ECC_BASE = 1 << HADDR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [HADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               rsp_corrected,
  output logic               rsp_uncorrectable,
  output logic               mem_en,
  output logic               mem_we,
  output logic [MADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata
);
  localparam int PAR_W = iecc_pkg::par_bits(DATA_W);

  logic [1:0]        rst_sync_q;
  logic              rst_n_int;
  logic [PAR_W:0]    enc_code;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rd_data_q;
  logic [PAR_W:0]    rd_code_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  iecc_seq #(
    .DATA_W   (DATA_W),
    .HADDR_W  (HADDR_W),
    .MADDR_W  (MADDR_W),
    .ECC_BASE (ECC_BASE),
    .PAR_W    (PAR_W)
  ) seq_i (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_ready (req_ready),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .enc_code  (enc_code),
    .wdata_q   (wdata_q),
    .rd_data_q (rd_data_q),
    .rd_code_q (rd_code_q)
  );

  iecc_encoder #(.DATA_W(DATA_W), .PAR_W(PAR_W)) wr_enc_i (
    .data_i (wdata_q),
    .code_o (enc_code)
  );

  iecc_decoder #(.DATA_W(DATA_W), .PAR_W(PAR_W)) rd_dec_i (
    .data_i      (rd_data_q),
    .code_i      (rd_code_q),
    .data_o      (rsp_rdata),
    .corrected_o (rsp_corrected),
    .uncorr_o    (rsp_uncorrectable)
  );

  // R9
  // rsp_hold_chk: an untaken response stays valid with unchanged data
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // R8
  // flag_excl_chk: never both corrected and uncorrectable
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    rsp_valid |-> !(rsp_corrected && rsp_uncorrectable));

endmodule

// File: tb/inline_ecc_sequencer_tb_top.sv
module inline_ecc_sequencer_tb_top;
  localparam int DW   = 32;
  localparam int HW   = 4;
  localparam int MW   = 5;
  localparam int BASE = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_ready, req_write;
  logic [HW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          rsp_valid, rsp_ready;
  logic [DW-1:0] rsp_rdata;
  logic          rsp_corrected, rsp_uncorrectable;
  logic          mem_en, mem_we;
  logic [MW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;

  logic [DW-1:0] mem_q [0:(1<<MW)-1];
  logic          inj_go;
  logic [MW-1:0] inj_addr;
  logic [DW-1:0] inj_mask;

  int n_chk  = 0;
  int n_fail = 0;

  inline_ecc_sequencer dut_i (
    .clk               (clk),
    .rst_n             (rst_n),
    .req_valid         (req_valid),
    .req_ready         (req_ready),
    .req_write         (req_write),
    .req_addr          (req_addr),
    .req_wdata         (req_wdata),
    .rsp_valid         (rsp_valid),
    .rsp_ready         (rsp_ready),
    .rsp_rdata         (rsp_rdata),
    .rsp_corrected     (rsp_corrected),
    .rsp_uncorrectable (rsp_uncorrectable),
    .mem_en            (mem_en),
    .mem_we            (mem_we),
    .mem_addr          (mem_addr),
    .mem_wdata         (mem_wdata),
    .mem_rdata         (mem_rdata)
  );

  always #10 clk = ~clk;

  // RAM model with one-cycle read latency and an error injection port
  always @(posedge clk) begin
    if (inj_go) mem_q[inj_addr] <= mem_q[inj_addr] ^ inj_mask;
    else if (mem_en) begin
      if (mem_we) mem_q[mem_addr] <= mem_wdata;
      mem_rdata <= mem_q[mem_addr];
    end
  end

  function automatic logic [6:0] ecc_ref(logic [31:0] d);
    logic [38:0] cw;
    logic [6:0]  r;
    logic        b;
    int          di;
    cw = '0;
    di = 0;
    for (int p = 1; p <= 38; p++) begin
      if (!(p == 1 || p == 2 || p == 4 || p == 8 || p == 16 || p == 32)) begin
        cw[p-1] = d[di];
        di++;
      end
    end
    r = '0;
    for (int k = 0; k < 6; k++) begin
      b = 1'b0;
      for (int p = 1; p <= 38; p++) if ((p & (1 << k)) != 0) b = b ^ cw[p-1];
      r[k] = b;
    end
    r[6] = (^d) ^ (^r[5:0]);
    return r;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic inject(int a, logic [DW-1:0] m);
    @(negedge clk);
    inj_addr = MW'(a);
    inj_mask = m;
    inj_go   = 1'b1;
    @(negedge clk);
    inj_go   = 1'b0;
  endtask

  task automatic do_write(int a, logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = HW'(a); req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 data write cmd", {mem_en, mem_we, 27'(mem_addr)}, {1'b1, 1'b1, 27'(a)});
    check("R2 data write word", 64'(mem_wdata), 64'(d));
    check("R9 busy during write", 64'(req_ready), 64'd0);
    @(negedge clk);
    check("R3 check write cmd", {mem_en, mem_we, 27'(mem_addr)}, {1'b1, 1'b1, 27'(a + BASE)});
    @(negedge clk);
    check("R10 idle after write", {req_ready, mem_en}, {1'b1, 1'b0});
    check("R2 stored data", 64'(mem_q[a]), 64'(d));
    check("R3 stored check word", 64'(mem_q[a + BASE]), 64'({25'd0, ecc_ref(d)}));
  endtask

  task automatic do_read(int a, logic [DW-1:0] d, logic ec, logic eu, logic chk_data,
                         string tag);
    logic [DW-1:0] held;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = HW'(a);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R4 data read cmd", {mem_en, mem_we, 27'(mem_addr)}, {1'b1, 1'b0, 27'(a)});
    check("R9 busy during read", 64'(req_ready), 64'd0);
    @(negedge clk);
    check("R4 check read cmd", {mem_en, mem_we, 27'(mem_addr)}, {1'b1, 1'b0, 27'(a + BASE)});
    @(negedge clk);
    check("R10 no cmd while waiting", {mem_en, rsp_valid}, {1'b0, 1'b0});
    @(negedge clk);
    check("R5 response valid", 64'(rsp_valid), 64'd1);
    check({tag, " flags"}, {rsp_corrected, rsp_uncorrectable}, {ec, eu});
    if (chk_data) check({tag, " data"}, 64'(rsp_rdata), 64'(d));
    held = rsp_rdata;
    @(negedge clk);
    check("R9 response held", {rsp_valid, 32'(rsp_rdata)}, {1'b1, 32'(held)});
    check("R10 no cmd while holding", 64'(mem_en), 64'd0);
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rsp_ready = 1'b0;
    check("R9 response taken", {rsp_valid, req_ready}, {1'b0, 1'b1});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    int a, kind, b1, b2;
    void'($urandom(32'd1234));
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_wdata = '0; rsp_ready = 1'b0; inj_go = 1'b0; inj_addr = '0; inj_mask = '0;
    for (int i = 0; i < (1 << MW); i++) mem_q[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset state", {req_ready, rsp_valid, mem_en}, {1'b1, 1'b0, 1'b0});

    // directed corners
    do_write(0, 32'h0000_0000);
    do_read(0, 32'h0000_0000, 1'b0, 1'b0, 1'b1, "R5 zeros");
    do_write(15, 32'hFFFF_FFFF);
    do_read(15, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1, "R5 ones");
    do_write(3, 32'hA5C3_0F96);
    inject(3, 32'h0000_0001);
    do_read(3, 32'hA5C3_0F96, 1'b1, 1'b0, 1'b1, "R6 bit0");
    do_write(4, 32'h1234_5678);
    inject(4, 32'h8000_0000);
    do_read(4, 32'h1234_5678, 1'b1, 1'b0, 1'b1, "R6 bit31");
    do_write(5, 32'hDEAD_BEEF);
    inject(5 + BASE, 32'h0000_0040);
    do_read(5, 32'hDEAD_BEEF, 1'b1, 1'b0, 1'b1, "R7 overall bit");
    do_write(6, 32'h0F0F_1111);
    inject(6, 32'h0000_0100);
    inject(6 + BASE, 32'h0000_0004);
    do_read(6, 32'h0F0F_1111, 1'b0, 1'b1, 1'b0, "R8 data+check");

    // random traffic with injected faults
    for (int it = 0; it < 80; it++) begin
      a    = int'($urandom % 16);
      d    = $urandom;
      kind = int'($urandom % 4);
      do_write(a, d);
      case (kind)
        1: begin
          b1 = int'($urandom % 32);
          inject(a, 32'd1 << b1);
          do_read(a, d, 1'b1, 1'b0, 1'b1, "R6 random data bit");
        end
        2: begin
          b1 = int'($urandom % 7);
          inject(a + BASE, 32'd1 << b1);
          do_read(a, d, 1'b1, 1'b0, 1'b1, "R7 random check bit");
        end
        3: begin
          b1 = int'($urandom % 32);
          b2 = (b1 + 1 + int'($urandom % 31)) % 32;
          inject(a, (32'd1 << b1) | (32'd1 << b2));
          do_read(a, d, 1'b0, 1'b1, 1'b0, "R8 random double");
        end
        default: do_read(a, d, 1'b0, 1'b0, 1'b1, "R5 random clean");
      endcase
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule